// File: doc/BRIEF.md
# EEPROM Write Command Sequencer

This block is the byte-level slave state machine for the write side of a two-wire serial EEPROM. A bit-level front end reports start events, stop events and each completed byte. For every byte, the sequencer decides whether the front end should pull the data line low on the ninth clock. It parses the command as a control byte, then two word-address bytes, then a stream of data bytes. Each data byte is handed to a page buffer together with the pointer it belongs to. A stop that closes a valid write asks for a commit to the array.

The control byte holds a fixed 4-bit device code, three chip-select bits and a direction bit. A read-direction command is handed off to a separate read path. While an internal write cycle runs, the `busy_i` input silences every acknowledge. When `wp_i` is high at the stop, the command is still acknowledged, but no commit follows.

Input events are single-cycle pulses. If several arrive in the same cycle, start wins over stop, and stop wins over a byte. All outputs are registered. They change on the clock edge that samples the event.

Top module: `eew_seq`

## Requirements
- R1: A byte after a start is a write control byte when bits [7:4] equal the device code (default 4'b1010), bits [3:1] equal `chip_sel_i` and bit 0 is 0. It is acknowledged with a one-cycle `ack_o` pulse. Any other control byte is not acknowledged, and all following bytes up to the next start are ignored.
- R2: A control byte with a matching code and chip select and with bit 0 = 1 produces a one-cycle `rd_handoff_o` pulse and no acknowledge. Later bytes are ignored until the next start.
- R3: The two bytes after a write control byte are acknowledged as the high and low word address. Bit 7 of the high byte is discarded. `addr_o` becomes {high[6:0], low} on the edge that samples the low byte.
- R4: Each later byte is acknowledged and strobed out on `wr_stb_o`, with `wr_data_o` set to the byte and `wr_addr_o` set to the pointer. The pointer then advances within its page: the low PAGE_W bits count up and wrap, and the upper bits never change.
- R5: A stop after at least one data byte, with `wp_i` low at that stop, gives a one-cycle `commit_o` pulse.
- R6: With `wp_i` high at the stop, every byte of the command is still acknowledged, but no `commit_o` follows. The next command is accepted at once.
- R7: While `busy_i` is high, no byte is acknowledged or strobed, including the control byte. The rest of that command is ignored until the next start.
- R8: A stop before any data byte gives no commit, and `addr_o` keeps the last fully loaded address. A repeated start never commits the bytes that came before it.
- R9: After reset, `ack_o`, `wr_stb_o`, `commit_o` and `rd_handoff_o` are 0, and `addr_o`, `wr_addr_o` and `wr_data_o` are 0.
- R10: A start in any state, including the ignore state, restarts parsing with the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start event pulse |
| stop_i | input | 1 | Stop event pulse |
| byte_vld_i | input | 1 | A received byte is complete |
| byte_i | input | 8 | Received byte |
| chip_sel_i | input | 3 | Strapped chip-select address |
| wp_i | input | 1 | Write protect, sampled at stop |
| busy_i | input | 1 | Internal write cycle in progress |
| ack_o | output | 1 | Acknowledge decision pulse for the byte just received |
| wr_stb_o | output | 1 | Data byte strobe to page buffer |
| wr_addr_o | output | ADDR_W | Pointer of the strobed data byte |
| wr_data_o | output | 8 | Strobed data byte |
| addr_o | output | ADDR_W | Current address pointer |
| commit_o | output | 1 | Request to start the internal write cycle |
| rd_handoff_o | output | 1 | Read command handed to read path |

## Verification
The bench builds the block with ADDR_W = 15, so writing 0xFF as the high address byte shows that the top bit is dropped. It also sets PAGE_W = 4, so the pointer wraps inside a 16-byte page after only a few data bytes. The device code stays at its default, and the chip select is strapped to 3'b101. With this setup, both a mismatched chip select and a read-direction byte can be sent from the same stimulus tasks.

// File: rtl/eew_pkg.sv
package eew_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } seq_st_t;

  // device code in the top nibble, chip select in the next three bits
  function automatic logic dev_select(input logic [7:0] b,
                                      input logic [2:0] cs,
                                      input logic [3:0] code);
    return (b[7:4] == code) && (b[3:1] == cs);
  endfunction

endpackage

// File: rtl/eew_ctrl_decode.sv
module eew_ctrl_decode #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic [7:0] byte_i,
  input  logic [2:0] chip_sel_i,
  output logic       hit_wr_o,
  output logic       hit_rd_o
);
  import eew_pkg::*;

  logic sel;

  always_comb begin
    sel      = dev_select(byte_i, chip_sel_i, DEV_CODE);
    hit_wr_o = sel && !byte_i[0];
    hit_rd_o = sel &&  byte_i[0];
  end

endmodule

// File: rtl/eew_addr_ptr.sv
module eew_addr_ptr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic              advance_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q;

  // advance inside the page; upper bits stay put
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] p);
    logic [PAGE_W-1:0] off;
    off = p[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
    return {p[ADDR_W-1:PAGE_W], off};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (load_hi_i) hi_q <= byte_i[HI_W-1:0];
      if (load_lo_i)      ptr_q <= {hi_q, byte_i};
      else if (advance_i) ptr_q <= page_step(ptr_q);
    end
  end

  assign ptr_o = ptr_q;

  // R3: a low-byte load places the received byte in the low bits of the pointer
  a_r3_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo_i |=> ptr_o[7:0] == $past(byte_i));

  // R4: advancing never disturbs the page number
  a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i && !load_lo_i |=> ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]));

endmodule

// File: rtl/eew_seq.sv
module eew_seq #(
  parameter int         ADDR_W   = 15,
  parameter int         PAGE_W   = 6,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              ack_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              commit_o,
  output logic              rd_handoff_o
);
  import eew_pkg::*;

  seq_st_t           st_q;
  logic              seen_data_q;
  logic              ack_q, stb_q, commit_q, rd_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;

  // named internal events
  logic byte_ev, take_byte, hit_wr, hit_rd;
  logic load_hi, load_lo, advance;
  logic [ADDR_W-1:0] ptr;

  assign byte_ev   = byte_vld_i && !start_i && !stop_i;
  assign take_byte = byte_ev && !busy_i;
  assign load_hi   = take_byte && (st_q == ST_AHI);
  assign load_lo   = take_byte && (st_q == ST_ALO);
  assign advance   = take_byte && (st_q == ST_DATA);

  eew_ctrl_decode #(.DEV_CODE(DEV_CODE)) u_dec (
    .byte_i     (byte_i),
    .chip_sel_i (chip_sel_i),
    .hit_wr_o   (hit_wr),
    .hit_rd_o   (hit_rd)
  );

  eew_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_hi_i (load_hi),
    .load_lo_i (load_lo),
    .advance_i (advance),
    .byte_i    (byte_i),
    .ptr_o     (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      seen_data_q <= 1'b0;
      ack_q       <= 1'b0;
      stb_q       <= 1'b0;
      commit_q    <= 1'b0;
      rd_q        <= 1'b0;
      waddr_q     <= '0;
      wdata_q     <= '0;
    end else begin
      ack_q    <= 1'b0;
      stb_q    <= 1'b0;
      commit_q <= 1'b0;
      rd_q     <= 1'b0;
      if (start_i) begin
        st_q        <= ST_CTRL;
        seen_data_q <= 1'b0;
      end else if (stop_i) begin
        commit_q    <= (st_q == ST_DATA) && seen_data_q && !wp_i;
        st_q        <= ST_IDLE;
        seen_data_q <= 1'b0;
      end else if (byte_ev) begin
        if (busy_i) begin
          if (st_q != ST_IDLE) st_q <= ST_SKIP;
        end else begin
          unique case (st_q)
            ST_CTRL: begin
              if (hit_wr) begin
                ack_q <= 1'b1;
                st_q  <= ST_AHI;
              end else begin
                rd_q <= hit_rd;
                st_q <= ST_SKIP;
              end
            end
            ST_AHI: begin
              ack_q <= 1'b1;
              st_q  <= ST_ALO;
            end
            ST_ALO: begin
              ack_q <= 1'b1;
              st_q  <= ST_DATA;
            end
            ST_DATA: begin
              ack_q       <= 1'b1;
              stb_q       <= 1'b1;
              waddr_q     <= ptr;
              wdata_q     <= byte_i;
              seen_data_q <= 1'b1;
            end
            default: st_q <= st_q;
          endcase
        end
      end
    end
  end

  assign ack_o        = ack_q;
  assign wr_stb_o     = stb_q;
  assign wr_addr_o    = waddr_q;
  assign wr_data_o    = wdata_q;
  assign addr_o       = ptr;
  assign commit_o     = commit_q;
  assign rd_handoff_o = rd_q;

  // R5: a commit only ever follows a stop event
  a_r5_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_i));

  // R6: protect high at the stop blocks the commit
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !$past(wp_i));

  // R7: no acknowledge for a byte that arrived while busy
  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) && $past(byte_vld_i) |-> !ack_o && !wr_stb_o);

  // R4: every strobed data byte is acknowledged, and its pointer lies in the current page
  a_r4_stb_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ack_o && (wr_addr_o[ADDR_W-1:PAGE_W] == addr_o[ADDR_W-1:PAGE_W]));

  // R2: a read handoff is never acknowledged here
  a_r2_rd_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_handoff_o |-> !ack_o);

  // R9: result pulses are mutually exclusive
  a_r9_pulses_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_o, wr_stb_o, rd_handoff_o}));

endmodule

// File: tb/sim_eew_seq.sv
module sim_eew_seq;
  localparam int AW = 15;
  localparam int PG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 0, stop_i = 0, byte_vld_i = 0, wp_i = 0, busy_i = 0;
  logic [7:0]    byte_i = 8'h00;
  logic [2:0]    chip_sel_i = 3'b101;
  logic          ack_o, wr_stb_o, commit_o, rd_handoff_o;
  logic [AW-1:0] wr_addr_o, addr_o;
  logic [7:0]    wr_data_o;

  eew_seq #(.ADDR_W(AW), .PAGE_W(PG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .chip_sel_i(chip_sel_i),
    .wp_i(wp_i), .busy_i(busy_i), .ack_o(ack_o), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .addr_o(addr_o),
    .commit_o(commit_o), .rd_handoff_o(rd_handoff_o)
  );

  always #2.5 clk = ~clk;

  int    checks = 0, failures = 0;
  string cur_req = "R9";

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle,1 ctrl,2 hi,3 lo,4 data,5 skip
  int m_st = 0, m_ptr = 0, m_hi = 0, m_nd = 0, m_waddr = 0, m_wdata = 0;
  int m_ack = 0, m_stb = 0, m_commit = 0, m_rd = 0;

  always @(posedge clk) begin
    m_ack = 0; m_stb = 0; m_commit = 0; m_rd = 0;
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_hi = 0; m_nd = 0; m_waddr = 0; m_wdata = 0;
    end else if (start_i) begin
      m_st = 1; m_nd = 0;
    end else if (stop_i) begin
      if (m_st == 4 && m_nd > 0 && !wp_i) m_commit = 1;
      m_st = 0; m_nd = 0;
    end else if (byte_vld_i && m_st != 0) begin
      if (busy_i) m_st = 5;
      else if (m_st == 1) begin
        if (byte_i[7:4] == 4'hA && byte_i[3:1] == chip_sel_i) begin
          if (byte_i[0]) begin m_rd = 1; m_st = 5; end
          else begin m_ack = 1; m_st = 2; end
        end else m_st = 5;
      end else if (m_st == 2) begin
        m_ack = 1; m_hi = byte_i % 128; m_st = 3;
      end else if (m_st == 3) begin
        m_ack = 1; m_ptr = m_hi * 256 + byte_i; m_st = 4;
      end else if (m_st == 4) begin
        m_ack = 1; m_stb = 1; m_waddr = m_ptr; m_wdata = byte_i; m_nd++;
        m_ptr = (m_ptr / (1 << PG)) * (1 << PG) + ((m_ptr + 1) % (1 << PG));
      end
    end
  end

  int n_ack = 0, n_stb = 0, n_commit = 0, n_rd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "ack_o", int'(ack_o), m_ack);
      check(cur_req, "wr_stb_o", int'(wr_stb_o), m_stb);
      check(cur_req, "commit_o", int'(commit_o), m_commit);
      check(cur_req, "rd_handoff_o", int'(rd_handoff_o), m_rd);
      check(cur_req, "addr_o", int'(addr_o), m_ptr);
      check(cur_req, "wr_addr_o", int'(wr_addr_o), m_waddr);
      check(cur_req, "wr_data_o", int'(wr_data_o), m_wdata);
      n_ack += int'(ack_o); n_stb += int'(wr_stb_o);
      n_commit += int'(commit_o); n_rd += int'(rd_handoff_o);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1; byte_i = b;
    @(negedge clk); byte_vld_i = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int a0, c0, s0, r0;
  initial begin
    idle(3);
    // R9 reset state
    check("R9", "ack_o", int'(ack_o), 0);
    check("R9", "commit_o", int'(commit_o), 0);
    check("R9", "addr_o", int'(addr_o), 0);
    check("R9", "wr_data_o", int'(wr_data_o), 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R1 R3 R4 R5 byte write
    cur_req = "R5"; a0 = n_ack; c0 = n_commit;
    pulse_start(); send(8'hAA); send(8'h12); send(8'h34); send(8'hA5); pulse_stop(); idle(2);
    check("R1", "acks", n_ack - a0, 4);
    check("R5", "commits", n_commit - c0, 1);
    check("R4", "wr_addr_o", int'(wr_addr_o), 'h1234);
    check("R4", "wr_data_o", int'(wr_data_o), 'hA5);

    // R3 don't-care top bit
    cur_req = "R3";
    pulse_start(); send(8'hAA); send(8'hFF); send(8'h00); send(8'h11); send(8'h22); pulse_stop(); idle(2);
    check("R3", "wr_addr_o", int'(wr_addr_o), 'h7F01);
    check("R3", "addr_o", int'(addr_o), 'h7F02);

    // R4 page wrap (16-byte page)
    cur_req = "R4";
    pulse_start(); send(8'hAA); send(8'h0A); send(8'h3E);
    for (int k = 0; k < 4; k++) send(8'h40 + 8'(k));
    pulse_stop(); idle(2);
    check("R4", "wr_addr_o", int'(wr_addr_o), 'h0A31);
    check("R4", "addr_o", int'(addr_o), 'h0A32);

    // R6 write protect
    cur_req = "R6"; a0 = n_ack; c0 = n_commit; wp_i = 1;
    pulse_start(); send(8'hAA); send(8'h01); send(8'h00); send(8'h55); pulse_stop();
    wp_i = 0; idle(2);
    check("R6", "acks", n_ack - a0, 4);
    check("R6", "commits", n_commit - c0, 0);

    // R7 busy
    cur_req = "R7"; a0 = n_ack; s0 = n_stb; busy_i = 1;
    pulse_start(); send(8'hAA); send(8'h02); send(8'h00); send(8'h66); pulse_stop();
    busy_i = 0; idle(2);
    check("R7", "acks", n_ack - a0, 0);
    check("R7", "strobes", n_stb - s0, 0);

    // R1 chip-select mismatch
    cur_req = "R1"; a0 = n_ack; c0 = n_commit;
    pulse_start(); send(8'hA2); send(8'h03); send(8'h00); send(8'h77); pulse_stop(); idle(2);
    check("R1", "acks", n_ack - a0, 0);
    check("R1", "commits", n_commit - c0, 0);

    // R2 read handoff, then R10 restart from skip state
    cur_req = "R2"; a0 = n_ack; r0 = n_rd;
    pulse_start(); send(8'hAB); send(8'h04); send(8'h00);
    check("R2", "handoffs", n_rd - r0, 1);
    check("R2", "acks", n_ack - a0, 0);
    cur_req = "R10";
    pulse_start(); send(8'hAA); send(8'h04); send(8'h08); send(8'h99); pulse_stop(); idle(2);
    check("R10", "wr_addr_o", int'(wr_addr_o), 'h0408);

    // R8 stop before data
    cur_req = "R8"; c0 = n_commit;
    pulse_start(); send(8'hAA); send(8'h05); send(8'h10); pulse_stop(); idle(2);
    check("R8", "addr_o", int'(addr_o), 'h0510);
    pulse_start(); send(8'hAA); send(8'h06); pulse_stop(); idle(2);
    check("R8", "addr_o", int'(addr_o), 'h0510);
    check("R8", "commits", n_commit - c0, 0);

    // R8 R10 repeated start after data
    cur_req = "R10"; c0 = n_commit;
    pulse_start(); send(8'hAA); send(8'h07); send(8'h00); send(8'h88);
    pulse_start(); send(8'hAA); send(8'h07); send(8'h20); send(8'h99); pulse_stop(); idle(2);
    check("R8", "commits", n_commit - c0, 1);
    check("R10", "wr_addr_o", int'(wr_addr_o), 'h0720);

    idle(3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule